// File: doc/BRIEF.md
# Asynchronous Parallel Memory Read Controller

This block runs read cycles on an external asynchronous parallel memory such as a NOR flash. Each read cycle is split into three phases, each with its own programmable cycle count: a setup phase, in which chip select and address are driven; an access phase, in which read enable is asserted; and a hold phase, which keeps chip select and address steady after read enable is released. After reset the block uses a slow, safe timing: 4 setup, 15 access and 3 hold cycles, with the external ready line ignored. A configuration load strobe can replace these values while the block is idle.

A single request port carries the address and the request options, and returns the data with a one-cycle valid strobe. Each request selects its own options. It can choose an 8-bit or 16-bit memory bus. It can ask for a byte or a 16-bit word. It can also raise a boot flag, which replaces the address with the fixed first-fetch location 0x2000_0000. When a word is requested over an 8-bit bus, the block performs two byte cycles at consecutive addresses and joins the two bytes, low byte first. If the ready line is enabled, the memory can lengthen the access phase.

Top module: `pmem_rd_ctrl`

## Requirements
- R1: After reset, mem_cs_n and mem_oe_n are 1, rd_valid is 0 and req_ready is 1. The timing in force is 4 setup, 15 access and 3 hold cycles, with mem_rdy ignored.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready stays 0 while mem_cs_n is 0, and it is 1 again in the cycle rd_valid is 1.
- R3: Each byte or word cycle begins with a setup phase of the programmed length. During this phase mem_cs_n is 0, mem_oe_n is 1, and mem_addr already holds the cycle's address.
- R4: The access phase follows setup. In it mem_oe_n is 0 for the programmed access count, mem_addr is held, and mem_dq is captured in the last access cycle.
- R5: The hold phase follows access. mem_cs_n stays 0 and mem_oe_n is 1 for the programmed hold count. A single-cycle request therefore keeps mem_cs_n low for setup+access+hold cycles.
- R6: In the cycle after the final hold cycle, rd_valid is 1 for exactly one cycle and rd_data carries the result.
- R7: When the ready enable is 0, mem_rdy has no effect, and the access phase lasts exactly the programmed count.
- R8: When the ready enable is 1, the access phase does not end before the programmed count. It then continues for as long as mem_rdy is 0.
- R9: A cfg_load pulse while req_ready is 1 replaces the setup, access and hold counts and the ready enable. A count of 0 behaves as 1.
- R10: A cfg_load pulse while a request is in progress is ignored. Later requests keep the earlier timing.
- R11: When req_word is 1 on a 16-bit bus (req_bus8 = 0), rd_data is all 16 bits of mem_dq. When req_word is 0, on either bus, rd_data is {8'h00, mem_dq[7:0]}.
- R12: When req_bus8 = 1 and req_word = 1, two complete cycles run, at addr and then at addr+1. rd_data = {second mem_dq[7:0], first mem_dq[7:0]}, and mem_dq[15:8] is ignored.
- R13: When req_boot = 1, the cycle address is 0x2000_0000, whatever the value of req_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load new timing (taken only while idle) |
| cfg_setup | input | CNT_W | Setup cycle count |
| cfg_access | input | CNT_W | Minimum access cycle count |
| cfg_hold | input | CNT_W | Hold cycle count |
| cfg_rdy_en | input | 1 | Honour mem_rdy during access |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | AW | Request address |
| req_boot | input | 1 | Use the fixed boot address instead of req_addr |
| req_bus8 | input | 1 | 1: 8-bit memory bus, 0: 16-bit |
| req_word | input | 1 | 1: 16-bit result, 0: byte result |
| rd_valid | output | 1 | One-cycle result strobe |
| rd_data | output | DW | Read result |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory read enable, active low |
| mem_addr | output | AW | Memory address |
| mem_dq | input | DW | Memory data |
| mem_rdy | input | 1 | Memory ready (high = data can complete) |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit data path and 5-bit counters. With these values the reset timing of 4/15/3 can be measured directly. The bench also loads all-zero counts to exercise the clamp to one cycle. A scoreboarded memory model drives mem_rdy a chosen number of cycles into each access phase. This lets one bench cover ready held low while disabled, ready arriving after the minimum count, and ready arriving before it. It also drives junk on the upper data lanes in 8-bit mode, so the byte-assembly paths are seen.

// File: rtl/pmem_rd_pkg.sv
package pmem_rd_pkg;

  // Phase of the external read cycle
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2,
    PH_HOLD   = 2'd3
  } pmem_phase_e;

endpackage

// File: rtl/pmem_tcfg.sv
module pmem_tcfg #(
  parameter int CNT_W      = 5,
  parameter int DEF_SETUP  = 4,
  parameter int DEF_ACCESS = 15,
  parameter int DEF_HOLD   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle,
  input  logic             cfg_load,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_access,
  input  logic [CNT_W-1:0] cfg_hold,
  input  logic             cfg_rdy_en,
  output logic [CNT_W-1:0] setup_len,
  output logic [CNT_W-1:0] access_len,
  output logic [CNT_W-1:0] hold_len,
  output logic             rdy_en
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] setup_q, setup_d;
  logic [CNT_W-1:0] access_q, access_d;
  logic [CNT_W-1:0] hold_q, hold_d;
  logic             rdy_en_q, rdy_en_d;
  logic             load_en;

  // new timing is accepted only between requests
  assign load_en = cfg_load & idle;

  always_comb begin
    setup_d  = setup_q;
    access_d = access_q;
    hold_d   = hold_q;
    rdy_en_d = rdy_en_q;
    if (load_en) begin
      setup_d  = cfg_setup;
      access_d = cfg_access;
      hold_d   = cfg_hold;
      rdy_en_d = cfg_rdy_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q  <= CNT_W'(DEF_SETUP);
      access_q <= CNT_W'(DEF_ACCESS);
      hold_q   <= CNT_W'(DEF_HOLD);
      rdy_en_q <= 1'b0;
    end else begin
      setup_q  <= setup_d;
      access_q <= access_d;
      hold_q   <= hold_d;
      rdy_en_q <= rdy_en_d;
    end
  end

  // a zero count is run as a single cycle
  assign setup_len  = (setup_q  == '0) ? ONE : setup_q;
  assign access_len = (access_q == '0) ? ONE : access_q;
  assign hold_len   = (hold_q   == '0) ? ONE : hold_q;
  assign rdy_en     = rdy_en_q;

  // R10
  cfg_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> ($stable(setup_q) && $stable(access_q) && $stable(hold_q) && $stable(rdy_en_q)));

endmodule

// File: rtl/pmem_seq.sv
module pmem_seq
  import pmem_rd_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             two_beat_in,
  input  logic [CNT_W-1:0] setup_len,
  input  logic [CNT_W-1:0] access_len,
  input  logic [CNT_W-1:0] hold_len,
  input  logic             rdy_en,
  input  logic             mem_rdy,
  output pmem_phase_e      phase,
  output logic             beat,
  output logic             cap,
  output logic             next_beat,
  output logic             finish,
  output logic             cs_n,
  output logic             oe_n
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  pmem_phase_e      ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             beat_q, beat_d;
  logic             two_q, two_d;
  logic             cs_n_q, oe_n_q;

  always_comb begin
    ph_d      = ph_q;
    cnt_d     = cnt_q;
    beat_d    = beat_q;
    two_d     = two_q;
    cap       = 1'b0;
    next_beat = 1'b0;
    finish    = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d   = PH_SETUP;
          cnt_d  = ONE;
          beat_d = 1'b0;
          two_d  = two_beat_in;
        end
      end
      PH_SETUP: begin
        if (cnt_q >= setup_len) begin
          ph_d  = PH_ACCESS;
          cnt_d = ONE;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      PH_ACCESS: begin
        if (cnt_q >= access_len) begin
          // minimum met: finish unless the memory holds us off
          if (!rdy_en || mem_rdy) begin
            cap   = 1'b1;
            ph_d  = PH_HOLD;
            cnt_d = ONE;
          end
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      PH_HOLD: begin
        if (cnt_q >= hold_len) begin
          if (two_q && !beat_q) begin
            next_beat = 1'b1;
            beat_d    = 1'b1;
            ph_d      = PH_SETUP;
            cnt_d     = ONE;
          end else begin
            finish = 1'b1;
            ph_d   = PH_IDLE;
          end
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      beat_q <= 1'b0;
      two_q  <= 1'b0;
      cs_n_q <= 1'b1;
      oe_n_q <= 1'b1;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      beat_q <= beat_d;
      two_q  <= two_d;
      cs_n_q <= (ph_d == PH_IDLE);
      oe_n_q <= (ph_d != PH_ACCESS);
    end
  end

  assign phase = ph_q;
  assign beat  = beat_q;
  assign cs_n  = cs_n_q;
  assign oe_n  = oe_n_q;

  // R8
  rdy_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ACCESS && rdy_en && !mem_rdy) |=> (ph_q == PH_ACCESS));

  // R7
  rdy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ACCESS && !rdy_en && cnt_q >= access_len) |=> (ph_q == PH_HOLD));

  // R4
  access_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ACCESS && cnt_q < access_len) |=> (ph_q == PH_ACCESS));

endmodule

// File: rtl/pmem_asm.sv
module pmem_asm #(
  parameter int          AW        = 32,
  parameter int          DW        = 16,
  parameter logic [AW-1:0] BOOT_ADDR = 32'h2000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] req_addr,
  input  logic          req_boot,
  input  logic          req_bus8,
  input  logic          req_word,
  input  logic          cap,
  input  logic          next_beat,
  input  logic          finish,
  input  logic          beat,
  input  logic [DW-1:0] mem_dq,
  output logic [AW-1:0] mem_addr,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  localparam int BW = DW / 2;

  logic [AW-1:0] addr_q, addr_d;
  logic          bus8_q, bus8_d;
  logic          word_q, word_d;
  logic [BW-1:0] lo_q, lo_d;
  logic [BW-1:0] hi_q, hi_d;
  logic          valid_q;

  always_comb begin
    addr_d = addr_q;
    bus8_d = bus8_q;
    word_d = word_q;
    if (start) begin
      addr_d = req_boot ? BOOT_ADDR : req_addr;
      bus8_d = req_bus8;
      word_d = req_word;
    end else if (next_beat) begin
      addr_d = addr_q + AW'(1);
    end
  end

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (cap) begin
      if (!beat) begin
        lo_d = mem_dq[BW-1:0];
        hi_d = (!bus8_q && word_q) ? mem_dq[DW-1:BW] : '0;
      end else begin
        hi_d = mem_dq[BW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      bus8_q  <= 1'b0;
      word_q  <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      bus8_q  <= bus8_d;
      word_q  <= word_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      valid_q <= finish;
    end
  end

  assign mem_addr = addr_q;
  assign rd_valid = valid_q;
  assign rd_data  = {hi_q, lo_q};

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R12
  beat_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    next_beat |=> (mem_addr == $past(mem_addr) + AW'(1)));

  // R6
  data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> $stable(rd_data));

endmodule

// File: rtl/pmem_rd_ctrl.sv
module pmem_rd_ctrl
  import pmem_rd_pkg::*;
#(
  parameter int            AW         = 32,
  parameter int            DW         = 16,
  parameter int            CNT_W      = 5,
  parameter int            DEF_SETUP  = 4,
  parameter int            DEF_ACCESS = 15,
  parameter int            DEF_HOLD   = 3,
  parameter logic [AW-1:0] BOOT_ADDR  = 32'h2000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [CNT_W-1:0] cfg_setup,
  input  logic [CNT_W-1:0] cfg_access,
  input  logic [CNT_W-1:0] cfg_hold,
  input  logic             cfg_rdy_en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_boot,
  input  logic             req_bus8,
  input  logic             req_word,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  output logic             mem_cs_n,
  output logic             mem_oe_n,
  output logic [AW-1:0]    mem_addr,
  input  logic [DW-1:0]    mem_dq,
  input  logic             mem_rdy
);

  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_pipe;
  logic              srst_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign srst_n = rst_pipe[SYNC_N-1];

  pmem_phase_e      phase;
  logic             beat, cap, next_beat, finish, start, idle;
  logic [CNT_W-1:0] setup_len, access_len, hold_len;
  logic             rdy_en;

  assign idle      = (phase == PH_IDLE);
  assign req_ready = idle;
  assign start     = req_valid & idle;

  pmem_tcfg #(
    .CNT_W(CNT_W), .DEF_SETUP(DEF_SETUP), .DEF_ACCESS(DEF_ACCESS), .DEF_HOLD(DEF_HOLD)
  ) u_tcfg (
    .clk(clk), .rst_n(srst_n), .idle(idle), .cfg_load(cfg_load),
    .cfg_setup(cfg_setup), .cfg_access(cfg_access), .cfg_hold(cfg_hold),
    .cfg_rdy_en(cfg_rdy_en), .setup_len(setup_len), .access_len(access_len),
    .hold_len(hold_len), .rdy_en(rdy_en)
  );

  pmem_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(srst_n), .start(start), .two_beat_in(req_bus8 & req_word),
    .setup_len(setup_len), .access_len(access_len), .hold_len(hold_len),
    .rdy_en(rdy_en), .mem_rdy(mem_rdy), .phase(phase), .beat(beat), .cap(cap),
    .next_beat(next_beat), .finish(finish), .cs_n(mem_cs_n), .oe_n(mem_oe_n)
  );

  pmem_asm #(.AW(AW), .DW(DW), .BOOT_ADDR(BOOT_ADDR)) u_asm (
    .clk(clk), .rst_n(srst_n), .start(start), .req_addr(req_addr),
    .req_boot(req_boot), .req_bus8(req_bus8), .req_word(req_word), .cap(cap),
    .next_beat(next_beat), .finish(finish), .beat(beat), .mem_dq(mem_dq),
    .mem_addr(mem_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // R2
  accept_cs_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(mem_cs_n) |-> $past(req_valid && req_ready));

  // R2
  busy_ready_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !mem_cs_n |-> !req_ready);

  // R4
  oe_in_cs_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !mem_oe_n |-> !mem_cs_n);

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

endmodule

// File: tb/sim_pmem_rd_ctrl.sv
module sim_pmem_rd_ctrl;

  localparam int AW = 32;
  localparam int DW = 16;
  localparam int CW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          cfg_load;
  logic [CW-1:0] cfg_setup, cfg_access, cfg_hold;
  logic          cfg_rdy_en;
  logic          req_valid, req_ready;
  logic [AW-1:0] req_addr;
  logic          req_boot, req_bus8, req_word;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          mem_cs_n, mem_oe_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq;
  logic          mem_rdy;

  pmem_rd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_setup(cfg_setup),
    .cfg_access(cfg_access), .cfg_hold(cfg_hold), .cfg_rdy_en(cfg_rdy_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_boot(req_boot), .req_bus8(req_bus8), .req_word(req_word),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_rdy(mem_rdy)
  );

  function automatic logic [15:0] mem_word(logic [31:0] a);
    return a[15:0] ^ {a[7:0], a[15:8]} ^ 16'hA55A;
  endfunction

  assign mem_dq = mem_oe_n ? 16'hFFFF : mem_word(mem_addr);

  typedef struct {
    logic [15:0] data;
    logic [31:0] a0;
    logic [31:0] a1;
    int          cs;
    int          su;
    int          ac;
    string       td;
    string       ta;
    string       tc;
  } exp_t;

  exp_t sbq[$];
  int   n_chk = 0;
  int   n_bad = 0;

  int cur_s = 4, cur_a = 15, cur_h = 3;
  bit cur_r = 1'b0;
  int rdy_delay = 1000;
  bit mon_on = 1'b0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int clamp1(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // ---------------- monitor / memory ready model ----------------
  int          cs_cnt = 0, su_cnt = 0, oe_run = 0, oec = 0;
  bit          seen_oe = 0, prev_oe_low = 0, busy_rdy = 0;
  logic [31:0] a_first = '0, a_last = '0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (rd_valid) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R6", "unexpected rd_valid", 1, 0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          chk(rd_data == e.data, e.td, "rd_data", rd_data, e.data);
          chk(a_first == e.a0, (e.td == "R13") ? "R13" : "R3", "setup address", a_first, e.a0);
          chk(a_last == e.a1, (e.td == "R12") ? "R12" : "R4", "last access address", a_last, e.a1);
          chk(su_cnt == e.su, "R3", "setup cycles", su_cnt, e.su);
          chk(oe_run == e.ac, e.ta, "access cycles", oe_run, e.ac);
          chk(cs_cnt == e.cs, e.tc, "chip select cycles", cs_cnt, e.cs);
          chk(req_ready && !busy_rdy, "R2", "req_ready behaviour", {req_ready, busy_rdy}, 2);
        end
        cs_cnt = 0; su_cnt = 0; seen_oe = 0; busy_rdy = 0;
      end
      if (!mem_cs_n) begin
        cs_cnt++;
        if (cs_cnt == 1) a_first = mem_addr;
        if (req_ready) busy_rdy = 1;
        if (mem_oe_n && !seen_oe) su_cnt++;
      end
      if (!mem_oe_n) begin
        if (!prev_oe_low) begin
          oe_run = 0;
          a_last = mem_addr;
        end
        oe_run++;
        seen_oe = 1;
      end
      prev_oe_low = !mem_oe_n;
    end
    if (!mem_oe_n) begin
      oec++;
      mem_rdy = (oec >= rdy_delay);
    end else begin
      oec = 0;
      mem_rdy = 1'b0;
    end
  end

  // ---------------- driver ----------------
  task automatic set_cfg(int s, int a, int h, bit r);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_setup = CW'(s); cfg_access = CW'(a); cfg_hold = CW'(h); cfg_rdy_en = r;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    cur_s = s; cur_a = a; cur_h = h; cur_r = r;
  endtask

  task automatic rd(logic [31:0] addr, bit boot, bit bus8, bit word,
                    string td, string ta, string tc, bit poke);
    exp_t        e;
    int          s, a, h, acc, beats;
    logic [31:0] base;
    logic [15:0] w0, w1;
    s = clamp1(cur_s); a = clamp1(cur_a); h = clamp1(cur_h);
    acc   = (cur_r && rdy_delay > a) ? rdy_delay : a;
    beats = (bus8 && word) ? 2 : 1;
    base  = boot ? 32'h2000_0000 : addr;
    w0 = mem_word(base);
    w1 = mem_word(base + 32'd1);
    if (bus8) e.data = word ? {w1[7:0], w0[7:0]} : {8'h00, w0[7:0]};
    else      e.data = word ? w0 : {8'h00, w0[7:0]};
    e.a0 = base;
    e.a1 = (beats == 2) ? base + 32'd1 : base;
    e.cs = beats * (s + acc + h);
    e.su = s; e.ac = acc;
    e.td = td; e.ta = ta; e.tc = tc;
    sbq.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_boot = boot; req_bus8 = bus8; req_word = word;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      // R10: attempt a timing change mid-transfer
      repeat (2) @(negedge clk);
      cfg_setup = CW'(7); cfg_access = CW'(7); cfg_hold = CW'(7); cfg_rdy_en = 1'b1;
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
    end
    while (sbq.size() != 0) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R6 watchdog expired: got %0h expected %0h", 0, 1);
    summary();
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; cfg_setup = '0; cfg_access = '0; cfg_hold = '0;
    cfg_rdy_en = 1'b0; req_valid = 1'b0; req_addr = '0; req_boot = 1'b0;
    req_bus8 = 1'b0; req_word = 1'b0; mem_rdy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(mem_cs_n == 1'b1, "R1", "mem_cs_n after reset", mem_cs_n, 1);
    chk(mem_oe_n == 1'b1, "R1", "mem_oe_n after reset", mem_oe_n, 1);
    chk(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    mon_on = 1'b1;

    // R1 default timing, R11 16-bit word on 16-bit bus
    rd(32'h0000_0100, 1'b0, 1'b0, 1'b1, "R11", "R4", "R1", 1'b0);
    // R7: ready held low but not enabled
    rd(32'h0000_0A37, 1'b0, 1'b0, 1'b0, "R11", "R7", "R5", 1'b0);
    // R13 boot address
    rd(32'h0000_1234, 1'b1, 1'b0, 1'b1, "R13", "R4", "R5", 1'b0);

    // R9 new timing with ready enabled
    set_cfg(2, 5, 1, 1'b1);
    rdy_delay = 9;
    rd(32'h0000_0200, 1'b0, 1'b0, 1'b1, "R6", "R8", "R9", 1'b0);
    rdy_delay = 3;
    rd(32'h0000_0204, 1'b0, 1'b0, 1'b1, "R6", "R8", "R9", 1'b0);
    rdy_delay = 0;
    // R12 two byte cycles
    rd(32'h0000_03FF, 1'b0, 1'b1, 1'b1, "R12", "R4", "R12", 1'b0);
    // R11 byte on 8-bit bus
    rd(32'h0000_0455, 1'b0, 1'b1, 1'b0, "R11", "R4", "R5", 1'b0);

    // R9 zero counts act as one
    rdy_delay = 1000;
    set_cfg(0, 0, 0, 1'b0);
    rd(32'h0000_0500, 1'b0, 1'b0, 1'b1, "R6", "R7", "R9", 1'b0);
    rd(32'h0000_0601, 1'b0, 1'b1, 1'b1, "R12", "R4", "R9", 1'b0);

    // R10 busy load ignored
    set_cfg(3, 4, 2, 1'b0);
    rd(32'h0000_0700, 1'b0, 1'b0, 1'b1, "R6", "R4", "R10", 1'b1);
    rd(32'h0000_0702, 1'b0, 1'b0, 1'b1, "R6", "R4", "R10", 1'b0);

    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R6", "outstanding results", sbq.size(), 0);
    summary();
    $finish;
  end

endmodule